// File: doc/BRIEF.md
# Indexed Global Configuration Register File

This block holds the chip-wide configuration registers that software reaches through two byte ports. A write on the index port stores an 8-bit register number. Data-port reads and writes then act on that register. The block has five registers: a control register whose bit 0 starts a soft reset, a logical-device number, a fixed identification byte, a fixed revision byte and a power-enable register. The logical-device number and the power enables are also driven out as registered outputs for the rest of the chip.

All access is gated by the `cfg_mode` input. Index writes and data writes are ignored while it is low, and `rd_data` returns zero. The full-reset condition is the OR of three synchronous, active-high inputs: main-supply power-on, standby-supply power-on and hard reset. It clears everything in the block. A soft reset requested through the control register clears only the logical-device number and the power enables. The stored index is left as it was. Both ports are single-cycle strobes with no back-pressure: every strobe is taken on the clock edge where it is high, and the read path is combinational from the stored index.

Top module: `glb_cfg_regs`

## Requirements
- R1: A cycle with `por_main`, `por_stby` or `hard_rst` high clears the stored index, `ldev_sel` and `pwr_en` to 0x00 at that clock edge.
- R2: `idx_we` stores `idx_wdata` only when `cfg_mode` is high. Data-port reads and writes address the most recently stored index.
- R3: While `cfg_mode` is low, `rd_data` is 0x00 and `dat_we` changes no register.
- R4: Index 0x07 is an 8-bit read/write register. A data write there updates `ldev_sel` at the same edge, and the value reads back unchanged.
- R5: Index 0x20 always reads 0x59, and writes to it have no effect.
- R6: Index 0x21 always reads the `REV_ID` parameter value, and writes to it have no effect.
- R7: Index 0x22 is the power register. Only bits 0, 2, 3, 4, 5 and 6 (mask 0x7D) are writable. Bits 1 and 7 read as 0 and are 0 on `pwr_en`.
- R8: A data write of 0x02 with bit 0 set clears `ldev_sel` and `pwr_en` at the following clock edge, not the write edge. A write to 0x02 with bit 0 clear has no effect, and index 0x02 always reads 0x00.
- R9: Every index other than 0x07, 0x20, 0x21 and 0x22 reads 0x00. A write to such an index changes no register, except the soft reset of R8. All 8 index bits are decoded, so there is no aliasing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_main | input | 1 | Main-supply power-on reset, synchronous, active high |
| por_stby | input | 1 | Standby-supply power-on reset, synchronous, active high |
| hard_rst | input | 1 | Hard reset, synchronous, active high |
| cfg_mode | input | 1 | Configuration mode; high enables both ports |
| idx_we | input | 1 | Index port write strobe |
| idx_wdata | input | 8 | Register number to store |
| dat_we | input | 1 | Data port write strobe |
| dat_wdata | input | 8 | Data port write value |
| rd_data | output | 8 | Contents of the indexed register, 0x00 outside configuration mode |
| ldev_sel | output | 8 | Current logical-device number |
| pwr_en | output | 8 | Power enables; bits 1 and 7 are always 0 |

## Verification
A write changes a register at the edge where its strobe is sampled, and `rd_data` follows the index with no delay. The bench therefore drives on the falling edge and checks register values and read-back on the next falling edge. A soft reset lands one edge later than an ordinary write. The bench checks that the outputs still hold their values at the first falling edge after the request, and only expects them cleared at the second. The sweep over all 256 indices waits two edges after each write, so the soft-reset index and every ordinary index can be compared against the same model.

// File: rtl/glb_cfg_pkg.sv
package glb_cfg_pkg;
  localparam int DW = 8;
  localparam int IW = 8;

  typedef logic [DW-1:0] cfg_byte_t;
  typedef logic [IW-1:0] cfg_idx_t;

  localparam cfg_idx_t  IX_CTRL  = 8'h02;
  localparam cfg_idx_t  IX_LDEV  = 8'h07;
  localparam cfg_idx_t  IX_DEVID = 8'h20;
  localparam cfg_idx_t  IX_REV   = 8'h21;
  localparam cfg_idx_t  IX_PWR   = 8'h22;

  localparam cfg_byte_t DEVID_VAL = 8'h59;
  localparam cfg_byte_t PWR_MASK  = 8'h7D;
  localparam int        SRST_BIT  = 0;
endpackage

// File: rtl/glb_cfg_rstgen.sv
module glb_cfg_rstgen (
  input  logic clk,
  input  logic por_main,
  input  logic por_stby,
  input  logic hard_rst,
  input  logic soft_req,
  output logic full_rst,
  output logic srst_q,
  output logic bank_rst
);
  // Any of the three external sources forms the full reset.
  assign full_rst = por_main | por_stby | hard_rst;

  // The soft-reset request becomes a one-cycle pulse that acts on the next edge.
  always_ff @(posedge clk) begin
    if (full_rst) srst_q <= 1'b0;
    else          srst_q <= soft_req;
  end

  assign bank_rst = full_rst | srst_q;
endmodule

// File: rtl/glb_cfg_index.sv
module glb_cfg_index
  import glb_cfg_pkg::*;
(
  input  logic     clk,
  input  logic     full_rst,
  input  logic     cfg_mode,
  input  logic     idx_we,
  input  cfg_idx_t idx_wdata,
  output cfg_idx_t idx_q
);
  // Only a full reset clears the index; a soft reset leaves it.
  always_ff @(posedge clk) begin
    if (full_rst)                idx_q <= '0;
    else if (idx_we && cfg_mode) idx_q <= idx_wdata;
  end
endmodule

// File: rtl/glb_cfg_bank.sv
module glb_cfg_bank
  import glb_cfg_pkg::*;
#(
  parameter cfg_byte_t REV_ID = 8'h01
) (
  input  logic      clk,
  input  logic      bank_rst,
  input  logic      cfg_mode,
  input  cfg_idx_t  idx_q,
  input  logic      dat_we,
  input  cfg_byte_t dat_wdata,
  output logic      soft_req,
  output cfg_byte_t ldev_q,
  output cfg_byte_t pwr_q,
  output cfg_byte_t rd_data
);
  logic wr_ok;
  logic wr_ldev;
  logic wr_pwr;

  assign wr_ok    = dat_we & cfg_mode;
  assign wr_ldev  = wr_ok & (idx_q == IX_LDEV);
  assign wr_pwr   = wr_ok & (idx_q == IX_PWR);
  assign soft_req = wr_ok & (idx_q == IX_CTRL) & dat_wdata[SRST_BIT];

  always_ff @(posedge clk) begin
    if (bank_rst)     ldev_q <= '0;
    else if (wr_ldev) ldev_q <= dat_wdata;
  end

  // Only the bits set in PWR_MASK get a flop; the others are tied to zero.
  for (genvar b = 0; b < DW; b++) begin : g_pwr
    if (PWR_MASK[b]) begin : g_impl
      always_ff @(posedge clk) begin
        if (bank_rst)    pwr_q[b] <= 1'b0;
        else if (wr_pwr) pwr_q[b] <= dat_wdata[b];
      end
    end else begin : g_rsvd
      assign pwr_q[b] = 1'b0;
    end
  end

  // The whole index is decoded; the default covers reserved and write-only entries.
  always_comb begin
    rd_data = '0;
    if (cfg_mode) begin
      case (idx_q)
        IX_LDEV:  rd_data = ldev_q;
        IX_DEVID: rd_data = DEVID_VAL;
        IX_REV:   rd_data = REV_ID;
        IX_PWR:   rd_data = pwr_q;
        default:  rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/glb_cfg_regs.sv
module glb_cfg_regs
  import glb_cfg_pkg::*;
#(
  parameter logic [7:0] REV_ID = 8'h01
) (
  input  logic       clk,
  input  logic       por_main,
  input  logic       por_stby,
  input  logic       hard_rst,
  input  logic       cfg_mode,
  input  logic       idx_we,
  input  logic [7:0] idx_wdata,
  input  logic       dat_we,
  input  logic [7:0] dat_wdata,
  output logic [7:0] rd_data,
  output logic [7:0] ldev_sel,
  output logic [7:0] pwr_en
);
  logic      full_rst;
  logic      srst_q;
  logic      bank_rst;
  logic      soft_req;
  cfg_idx_t  idx_q;
  cfg_byte_t ldev_q;
  cfg_byte_t pwr_q;

  glb_cfg_rstgen u_rst (
    .clk      (clk),
    .por_main (por_main),
    .por_stby (por_stby),
    .hard_rst (hard_rst),
    .soft_req (soft_req),
    .full_rst (full_rst),
    .srst_q   (srst_q),
    .bank_rst (bank_rst)
  );

  glb_cfg_index u_idx (
    .clk       (clk),
    .full_rst  (full_rst),
    .cfg_mode  (cfg_mode),
    .idx_we    (idx_we),
    .idx_wdata (idx_wdata),
    .idx_q     (idx_q)
  );

  glb_cfg_bank #(.REV_ID(REV_ID)) u_bank (
    .clk       (clk),
    .bank_rst  (bank_rst),
    .cfg_mode  (cfg_mode),
    .idx_q     (idx_q),
    .dat_we    (dat_we),
    .dat_wdata (dat_wdata),
    .soft_req  (soft_req),
    .ldev_q    (ldev_q),
    .pwr_q     (pwr_q),
    .rd_data   (rd_data)
  );

  assign ldev_sel = ldev_q;
  assign pwr_en   = pwr_q;
endmodule

// File: rtl/glb_cfg_chk.sv
module glb_cfg_chk (
  input logic       clk,
  input logic       por_main,
  input logic       por_stby,
  input logic       hard_rst,
  input logic       cfg_mode,
  input logic       idx_we,
  input logic [7:0] idx_q,
  input logic       dat_we,
  input logic [7:0] dat_wdata,
  input logic       srst_q,
  input logic [7:0] rd_data,
  input logic [7:0] ldev_sel,
  input logic [7:0] pwr_en
);
  logic any_rst;
  assign any_rst = por_main | por_stby | hard_rst;

  // R1
  full_rst_clear_chk: assert property (@(posedge clk)
    any_rst |=> (ldev_sel == 8'h00 && pwr_en == 8'h00 && idx_q == 8'h00));

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (any_rst)
    (!cfg_mode || !idx_we) |=> $stable(idx_q));

  // R3
  rd_gate_chk: assert property (@(posedge clk) disable iff (any_rst)
    !cfg_mode |-> rd_data == 8'h00);

  // R4
  ldev_hold_chk: assert property (@(posedge clk) disable iff (any_rst)
    (!any_rst && !srst_q && !(dat_we && cfg_mode && idx_q == 8'h07)) |=> $stable(ldev_sel));

  // R7
  pwr_rsvd_chk: assert property (@(posedge clk) disable iff (any_rst)
    (pwr_en & 8'h82) == 8'h00);

  // R8
  soft_clear_chk: assert property (@(posedge clk) disable iff (any_rst)
    (dat_we && cfg_mode && idx_q == 8'h02 && dat_wdata[0]) |=> ##1 (ldev_sel == 8'h00 && pwr_en == 8'h00));
endmodule

bind glb_cfg_regs glb_cfg_chk u_chk (
  .clk       (clk),
  .por_main  (por_main),
  .por_stby  (por_stby),
  .hard_rst  (hard_rst),
  .cfg_mode  (cfg_mode),
  .idx_we    (idx_we),
  .idx_q     (idx_q),
  .dat_we    (dat_we),
  .dat_wdata (dat_wdata),
  .srst_q    (srst_q),
  .rd_data   (rd_data),
  .ldev_sel  (ldev_sel),
  .pwr_en    (pwr_en)
);

// File: tb/glb_cfg_regs_tb.sv
module glb_cfg_regs_tb_top;
  localparam logic [7:0] REV_T = 8'hC3;

  logic       clk = 1'b0;
  logic       por_main = 1'b1, por_stby = 1'b0, hard_rst = 1'b0;
  logic       cfg_mode = 1'b0, idx_we = 1'b0, dat_we = 1'b0;
  logic [7:0] idx_wdata = '0, dat_wdata = '0;
  logic [7:0] rd_data, ldev_sel, pwr_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_ldev, m_pwr;

  always #5 clk = ~clk;

  glb_cfg_regs #(.REV_ID(REV_T)) dut_i (
    .clk(clk), .por_main(por_main), .por_stby(por_stby), .hard_rst(hard_rst),
    .cfg_mode(cfg_mode), .idx_we(idx_we), .idx_wdata(idx_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata),
    .rd_data(rd_data), .ldev_sel(ldev_sel), .pwr_en(pwr_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_idx(input logic [7:0] v);
    idx_we = 1'b1; idx_wdata = v;
    @(negedge clk);
    idx_we = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    dat_we = 1'b1; dat_wdata = v;
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] i);
    case (i)
      8'h07:   return m_ldev;
      8'h20:   return 8'h59;
      8'h21:   return REV_T;
      8'h22:   return m_pwr;
      default: return 8'h00;
    endcase
  endfunction

  task automatic preload;
    wr_idx(8'h07); wr_dat(8'h3C);
    wr_idx(8'h22); wr_dat(8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_main = 1'b0;
    @(negedge clk);
    // R1: state after power-on
    chk("R1 reset ldev", ldev_sel, 8'h00);
    chk("R1 reset pwr", pwr_en, 8'h00);
    chk("R3 rd outside cfg", rd_data, 8'h00);

    cfg_mode = 1'b1;
    // R1: each reset source on its own
    for (int s = 0; s < 3; s++) begin
      preload();
      chk("R7 masked pwr", pwr_en, 8'h7D);
      chk("R7 pwr readback", rd_data, 8'h7D);
      if (s == 0) por_main = 1'b1; else if (s == 1) por_stby = 1'b1; else hard_rst = 1'b1;
      @(negedge clk);
      por_main = 1'b0; por_stby = 1'b0; hard_rst = 1'b0;
      chk("R1 src ldev", ldev_sel, 8'h00);
      chk("R1 src pwr", pwr_en, 8'h00);
      chk("R1 src idx cleared", rd_data, 8'h00);
    end

    // R2 / R3: gating by cfg_mode
    wr_idx(8'h07); wr_dat(8'h11);
    chk("R4 ldev write", ldev_sel, 8'h11);
    cfg_mode = 1'b0;
    wr_idx(8'h22);
    wr_dat(8'h55);
    chk("R3 rd zero", rd_data, 8'h00);
    chk("R3 write ignored", ldev_sel, 8'h11);
    chk("R3 pwr untouched", pwr_en, 8'h00);
    cfg_mode = 1'b1;
    @(negedge clk);
    chk("R2 index held", rd_data, 8'h11);

    // R8: soft reset timing
    wr_idx(8'h22); wr_dat(8'h3C);
    wr_idx(8'h07); wr_dat(8'h42);
    wr_idx(8'h02); wr_dat(8'hFE);
    @(negedge clk);
    chk("R8 bit0 clear no effect ldev", ldev_sel, 8'h42);
    chk("R8 bit0 clear no effect pwr", pwr_en, 8'h3C);
    chk("R8 ctrl reads zero", rd_data, 8'h00);
    wr_dat(8'h01);
    chk("R8 not yet cleared", ldev_sel, 8'h42);
    @(negedge clk);
    chk("R8 ldev cleared", ldev_sel, 8'h00);
    chk("R8 pwr cleared", pwr_en, 8'h00);

    // R9, R4-R7: sweep every index with a computed pattern
    m_ldev = 8'h00; m_pwr = 8'h00;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] v;
      v = 8'(i) ^ 8'hA5;
      wr_idx(8'(i));
      wr_dat(v);
      @(negedge clk);
      if (i == 8'h07) m_ldev = v;
      if (i == 8'h22) m_pwr = v & 8'h7D;
      if (i == 8'h02 && v[0]) begin m_ldev = 8'h00; m_pwr = 8'h00; end
      chk("R9 sweep read", rd_data, exp_rd(8'(i)));
      chk("R4 sweep ldev", ldev_sel, m_ldev);
      chk("R7 sweep pwr", pwr_en, m_pwr);
    end
    // R5 / R6: fixed values after writes
    wr_idx(8'h20); chk("R5 id", rd_data, 8'h59);
    wr_idx(8'h21); chk("R6 rev", rd_data, REV_T);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=00 expected=01");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule